// File: doc/BRIEF.md
# Global-History XOR Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds a table of 2-bit saturating counters and a shift register of the most recent resolved branch outcomes. A lookup forms a table index by XORing a slice of the branch address with the outcome history, reads the selected counter and reports taken when the counter sits in its upper half. The lookup is purely combinational, so the prediction and the index are available in the same cycle as the address.

When a branch resolves, the pipeline returns the index that was produced at prediction time together with the real outcome. The block moves that counter one step toward the outcome and pushes the outcome into the history. Because the history is shared by all branches, a single branch address can land on different counters depending on the path that led to it.

Top module: `ghist_xor_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not-taken, so every lookup predicts not-taken and a single taken update flips that entry to taken) and the history is all zeros.
- R2: The lookup index equals address bits [11:2] XORed with the 10-bit history, and is presented in the same cycle as the address.
- R3: A taken update increments the addressed counter, holding at 3 when it is already 3.
- R4: A not-taken update decrements the addressed counter, holding at 0 when it is already 0.
- R5: The prediction is taken (1) exactly when the counter selected by the lookup index is 2 or 3.
- R6: Each valid update shifts the history left by one, with the outcome (taken = 1) entering bit 0 and the oldest bit dropped.
- R7: An update trains only the counter named by the supplied index, whatever address is on the lookup port.
- R8: When a lookup and an update select the same counter in one cycle, the lookup reports the value held before that update.
- R9: While the update-valid input is low, the counters and the history do not change regardless of the other update inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | 32 | Branch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_index | output | 10 | Counter index used for this lookup |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_index | input | 10 | Index recorded at prediction time |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The hardest state to reach is a specific counter at a specific value, because the counter a lookup touches moves every time the history shifts. The stimulus tracks the expected history and, for every probe, chooses the address whose bits XOR with that history to the wanted index, so any counter can be read back after any training sequence. Saturation is shown by over-training one entry past its limit and then counting how many opposite outcomes it takes to flip the prediction.

// File: rtl/ghist_xor_predictor.sv
module ghist_xor_predictor #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int PC_LSB = 2,
  parameter int CTR_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_taken,
  output logic [IDX_W-1:0] lk_index,
  input  logic             up_valid,
  input  logic [IDX_W-1:0] up_index,
  input  logic             up_taken
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_MIN  = '0;
  localparam logic [CTR_W-1:0] CTR_TH   = CTR_W'(1 << (CTR_W-1));
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_TH - 1'b1;

  logic [CTR_W-1:0] tbl [ENTRIES];
  logic [IDX_W-1:0] hist;
  logic [CTR_W-1:0] cur, nxt;
  logic             unused_pc_bits;

  assign unused_pc_bits = ^{lk_pc[PC_W-1:PC_LSB+IDX_W], lk_pc[PC_LSB-1:0]};
  assign lk_index = lk_pc[PC_LSB +: IDX_W] ^ hist;
  assign lk_taken = tbl[lk_index] >= CTR_TH;

  assign cur = tbl[up_index];
  always_comb begin
    if (up_taken) nxt = (cur == CTR_MAX) ? cur : cur + 1'b1;
    else          nxt = (cur == CTR_MIN) ? cur : cur - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_INIT;
      hist <= '0;
    end else if (up_valid) begin
      tbl[up_index] <= nxt;
      hist <= {hist[IDX_W-2:0], up_taken};
    end
  end

  always_comb
    if (rst_n) assert_index_mix_R2: assert ((lk_index ^ hist) == lk_pc[PC_LSB +: IDX_W]);

  assert_sat_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && tbl[up_index] == CTR_MAX) |=> tbl[$past(up_index)] == CTR_MAX);

  assert_sat_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && tbl[up_index] == CTR_MIN) |=> tbl[$past(up_index)] == CTR_MIN);

  assert_train_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken) |=> tbl[$past(up_index)] >= $past(tbl[up_index]));

  assert_hist_newest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> hist[0] == $past(up_taken));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(hist));
endmodule

// File: tb/ghist_xor_predictor_test.sv
module ghist_xor_predictor_test;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic [31:0] lk_pc = '0;
  logic lk_taken;
  logic [9:0] lk_index;
  logic up_valid = 0, up_taken = 0;
  logic [9:0] up_index = '0;
  int checks = 0, fails = 0;
  bit done = 0;
  int mctr [1024];
  logic [9:0] mh;

  always #(CLK_PERIOD/2) clk = ~clk;

  ghist_xor_predictor uut (.clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_index(lk_index), .up_valid(up_valid), .up_index(up_index), .up_taken(up_taken));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic probe(string req, int idx);
    lk_pc = {20'b0, 10'(idx) ^ mh, 2'b00};
    #1;
    chk(req, lk_taken, mctr[idx] >= 2);
    chk("R2", lk_index, idx);
  endtask

  task automatic upd(int idx, bit t);
    @(negedge clk);
    up_valid = 1; up_index = 10'(idx); up_taken = t;
    @(negedge clk);
    up_valid = 0;
    if (t) mctr[idx] = (mctr[idx] == 3) ? 3 : mctr[idx] + 1;
    else   mctr[idx] = (mctr[idx] == 0) ? 0 : mctr[idx] - 1;
    mh = {mh[8:0], t};
  endtask

  task automatic t_reset;
    @(negedge clk);
    lk_pc = 32'h0000_0abc; #1;
    chk("R1", lk_index, 10'h2af);
    probe("R1", 0); probe("R1", 1023); probe("R1", 5);
    upd(5, 1);
    probe("R1", 5);
  endtask

  task automatic t_index;
    @(negedge clk);
    lk_pc = 32'hffff_fffc; #1;
    chk("R2", lk_index, 10'h3ff ^ mh);
    lk_pc = 32'h1234_5678; #1;
    chk("R2", lk_index, 10'(32'h1234_5678 >> 2) ^ mh);
  endtask

  task automatic t_sat;
    for (int i = 0; i < 6; i++) upd(77, 1);
    probe("R3", 77);
    upd(77, 0); probe("R3", 77);
    upd(77, 0); probe("R5", 77);
    for (int i = 0; i < 5; i++) upd(77, 0);
    upd(77, 1); probe("R4", 77);
    upd(77, 1); probe("R4", 77);
    upd(77, 1); probe("R5", 77);
  endtask

  task automatic t_hist;
    bit pat [12] = '{1,0,1,1,0,0,1,0,1,1,1,0};
    for (int i = 0; i < 12; i++) begin
      upd(300 + i, pat[i]);
      lk_pc = '0; #1;
      chk("R6", lk_index, mh);
    end
  endtask

  task automatic t_target;
    @(negedge clk);
    lk_pc = {20'b0, 10'd400 ^ mh, 2'b00};
    upd(500, 1); upd(500, 1);
    probe("R7", 500); probe("R7", 400);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    up_valid = 1; up_index = 10'd600; up_taken = 1;
    lk_pc = {20'b0, 10'd600 ^ mh, 2'b00}; #1;
    chk("R8", lk_taken, 0);
    @(negedge clk);
    up_valid = 0;
    mctr[600] = 2; mh = {mh[8:0], 1'b1};
    probe("R8", 600);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      up_index = 10'd700; up_taken = i[0];
    end
    lk_pc = '0; #1;
    chk("R9", lk_index, mh);
    probe("R9", 700);
    upd(700, 1); probe("R9", 700);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mctr[i] = 1;
    mh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_index; t_sat; t_hist; t_target; t_same_cycle; t_idle;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule